// File: doc/BRIEF.md
# Engine Activity Cycle Counter Bank

This block holds a set of cycle counters that measure how busy a group of engines is, so that a clock governor can estimate load over a sampling window. Each counter runs in one of two modes. In the first it advances on every clock, which gives the length of the window. In the second it advances only on cycles where at least one of the engine busy lines picked by its own mask is high. Software programs one counter as a total-cycle counter and another as a busy-cycle counter, reads both at the end of the window, and then zeroes them.

One counter, chosen by a parameter, also guards the window against running past its range. When its count reaches its programmed threshold, a sticky status flag is set. Software treats a window with that flag set as invalid and reports full load. The flag is cleared by writing 1 to it. A separate enable bit decides whether the flag also drives the interrupt line.

Registers are reached through a simple port that takes one read or write per cycle. All addresses are byte addresses, and address bits [1:0] are ignored. The per-counter registers sit in four groups of 0x40 bytes:

| Group | Address | Contents |
|---|---|---|
| Control | 0x000 + 4*i | mode in bit 0 |
| Mask | 0x040 + 4*i | busy mask |
| Threshold | 0x080 + 4*i | threshold |
| Count | 0x0C0 + 4*i | count value; reset bit |

The interrupt enable is at 0x104 and the status flag is at 0x100.

Top module: `cycle_load_counters`

## Requirements
- R1: After reset every count reads 0, every mode bit reads 0, every mask reads 0, every threshold reads 0x7FFFFFFF, and the status flag, the enable bit and `irq_o` are all 0.
- R2: With control bit 0 = 1 (count-always mode), a counter advances by one on every clock edge.
- R3: With control bit 0 = 0 (busy mode), a counter advances on an edge only when `busy_i & mask` is nonzero at that edge. With a zero mask it never advances.
- R4: A write to a counter's count register with bit 31 = 1 sets that count to 0. This holds even when a count event falls on the same edge. A count-register write with bit 31 = 0 leaves the count unchanged.
- R5: A threshold holds 31 bits, with bits [30:0] stored and bit 31 reading 0. The status flag is set on the edge where the count of counter `IRQ_SRC` (default 0) becomes equal to its threshold. Threshold crossings of the other counters do not set it.
- R6: Once set, the status flag stays set even when its counter is reset. It stays set through a status write with bit 0 = 0, and clears only on a status write with bit 0 = 1.
- R7: `irq_o` is high exactly when the status flag and enable bit 0 are both 1. With the enable at 0 the flag still latches but `irq_o` stays low.
- R8: A read strobe returns data on `reg_rdata_o`, with `reg_rvalid_o` high, in the cycle after the edge that samples it. The data shows register state from before that edge. Unmapped addresses, including counter indices at or above `NUM_CNT`, read 0.
- R9: When a threshold crossing and a status clear write land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| busy_i | input | NUM_BUSY | engine busy lines, sampled every edge |
| reg_wr_i | input | 1 | write strobe |
| reg_rd_i | input | 1 | read strobe |
| reg_addr_i | input | ADDR_W | byte address |
| reg_wdata_i | input | 32 | write data |
| reg_rdata_o | output | 32 | read data, one cycle after the strobe |
| reg_rvalid_o | output | 1 | read data valid |
| irq_o | output | 1 | status flag gated by the enable bit |

## Verification
The hardest cases to reach from the ports are the two same-edge collisions. The first is a counter reset against a count event. The second is a threshold crossing against a status clear write.

The stimulus reaches them by exact edge counting. It puts the counter in count-always mode, so every reset write collides with an increment, and the count read straight afterwards must be exactly 0. It then sets a small threshold, resets the counter on a known edge, and places the clear write on the edge where the count reaches the threshold. The flag is then read back. The same edge arithmetic lets the bench read the flag one edge before and one edge after the crossing.

// File: rtl/cyc_bank_pkg.sv
package cyc_bank_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned CNT_RST_BIT = 31;
  localparam int unsigned GRP_SLOTS   = 16;

  // per-counter register groups, selected by address bits [7:6]
  typedef enum logic [1:0] {
    GRP_CTRL = 2'd0,
    GRP_MASK = 2'd1,
    GRP_THR  = 2'd2,
    GRP_CNT  = 2'd3
  } reg_grp_e;

  typedef enum logic {
    MODE_BUSY = 1'b0,
    MODE_ALL  = 1'b1
  } cnt_mode_e;

  // word index inside the second 256-byte page
  localparam logic [5:0] STAT_WORD = 6'd0;
  localparam logic [5:0] EN_WORD   = 6'd1;
endpackage

// File: rtl/cyc_counter_unit.sv
module cyc_counter_unit
  import cyc_bank_pkg::*;
#(
  parameter int unsigned NUM_BUSY = 8,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned THR_W    = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BUSY-1:0] busy_i,
  input  logic                wr_ctrl_i,
  input  logic                wr_mask_i,
  input  logic                wr_thr_i,
  input  logic                wr_cnt_i,
  input  logic [REG_W-1:0]    wdata_i,
  output cnt_mode_e           mode_o,
  output logic [NUM_BUSY-1:0] mask_o,
  output logic [THR_W-1:0]    thr_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                hit_o
);
  localparam logic [THR_W-1:0] THR_RESET = '1;

  cnt_mode_e           mode_q, mode_d;
  logic [NUM_BUSY-1:0] mask_q, mask_d;
  logic [THR_W-1:0]    thr_q, thr_d;
  logic [CNT_W-1:0]    count_q, count_d, count_inc;
  logic                count_clr, count_evt, count_en, busy_sel;

  // next state
  always_comb begin
    mode_d    = wr_ctrl_i ? cnt_mode_e'(wdata_i[0]) : mode_q;
    mask_d    = wr_mask_i ? wdata_i[NUM_BUSY-1:0] : mask_q;
    thr_d     = wr_thr_i ? wdata_i[THR_W-1:0] : thr_q;
    busy_sel  = |(busy_i & mask_q);
    count_evt = (mode_q == MODE_ALL) || busy_sel;
    count_clr = wr_cnt_i && wdata_i[CNT_RST_BIT];
    count_inc = count_q + CNT_W'(1);
    count_en  = count_clr || count_evt;
    if (count_clr) begin
      count_d = '0;
    end else begin
      count_d = count_inc;
    end
    hit_o = count_evt && !count_clr && (count_inc == CNT_W'(thr_q));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_BUSY;
      mask_q <= '0;
      thr_q  <= THR_RESET;
    end else begin
      if (wr_ctrl_i) mode_q <= mode_d;
      if (wr_mask_i) mask_q <= mask_d;
      if (wr_thr_i)  thr_q  <= thr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign mode_o  = mode_q;
  assign mask_o  = mask_q;
  assign thr_o   = thr_q;
  assign count_o = count_q;

  // R2: count-always mode advances one step per edge
  a_r2_always_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ALL && !count_clr) |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R3: no selected busy line means no movement
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BUSY && (busy_i & mask_q) == '0 && !count_clr) |=> $stable(count_q));

  // R4: a reset write always leaves the count at zero
  a_r4_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    count_clr |=> (count_q == '0));
endmodule

// File: rtl/cyc_irq_ctrl.sv
module cyc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic stat_clr_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  output logic stat_o,
  output logic en_o,
  output logic irq_o
);
  logic stat_q, stat_d, stat_ce;
  logic en_q, en_d;

  always_comb begin
    stat_ce = hit_i || stat_clr_i;
    // a crossing on the same edge as a clear keeps the flag set
    stat_d  = hit_i ? 1'b1 : 1'b0;
    en_d    = en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (stat_ce) stat_q <= stat_d;
      if (en_wr_i) en_q   <= en_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = stat_q && en_q;

  // R6: the flag holds until an explicit clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !stat_clr_i) |=> stat_q);

  // R9: a crossing always leaves the flag set, clear or not
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> stat_q);
endmodule

// File: rtl/cyc_reg_decode.sv
module cyc_reg_decode
  import cyc_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic                           rd_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [REG_W-1:0]               wdata_i,
  input  logic [NUM_CNT-1:0][REG_W-1:0]  ctrl_rd_i,
  input  logic [NUM_CNT-1:0][REG_W-1:0]  mask_rd_i,
  input  logic [NUM_CNT-1:0][REG_W-1:0]  thr_rd_i,
  input  logic [NUM_CNT-1:0][REG_W-1:0]  cnt_rd_i,
  input  logic                           stat_rd_i,
  input  logic                           en_rd_i,
  output logic [NUM_CNT-1:0]             wr_ctrl_o,
  output logic [NUM_CNT-1:0]             wr_mask_o,
  output logic [NUM_CNT-1:0]             wr_thr_o,
  output logic [NUM_CNT-1:0]             wr_cnt_o,
  output logic                           stat_clr_o,
  output logic                           en_wr_o,
  output logic [REG_W-1:0]               rdata_o,
  output logic                           rvalid_o
);
  localparam int unsigned PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  reg_grp_e          grp;
  logic [3:0]        idx;
  logic [5:0]        word;
  logic              in_bank, stat_sel, en_sel;
  logic [NUM_CNT-1:0] idx_hit;
  logic [REG_W-1:0]  rdata_d, rdata_q;
  logic              rvalid_q;

  always_comb begin
    page     = addr_i[ADDR_W-1:8];
    grp      = reg_grp_e'(addr_i[7:6]);
    idx      = addr_i[5:2];
    word     = addr_i[7:2];
    in_bank  = (page == PAGE_W'(0));
    stat_sel = (page == PAGE_W'(1)) && (word == STAT_WORD);
    en_sel   = (page == PAGE_W'(1)) && (word == EN_WORD);
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    assign idx_hit[i]   = in_bank && (idx == 4'(i));
    assign wr_ctrl_o[i] = wr_i && idx_hit[i] && (grp == GRP_CTRL);
    assign wr_mask_o[i] = wr_i && idx_hit[i] && (grp == GRP_MASK);
    assign wr_thr_o[i]  = wr_i && idx_hit[i] && (grp == GRP_THR);
    assign wr_cnt_o[i]  = wr_i && idx_hit[i] && (grp == GRP_CNT);
  end

  assign stat_clr_o = wr_i && stat_sel && wdata_i[0];
  assign en_wr_o    = wr_i && en_sel;

  // read mux; unmatched addresses fall through to zero
  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (idx_hit[i]) begin
        unique case (grp)
          GRP_CTRL: rdata_d = ctrl_rd_i[i];
          GRP_MASK: rdata_d = mask_rd_i[i];
          GRP_THR:  rdata_d = thr_rd_i[i];
          GRP_CNT:  rdata_d = cnt_rd_i[i];
          default:  rdata_d = '0;
        endcase
      end
    end
    if (stat_sel) rdata_d = REG_W'(stat_rd_i);
    if (en_sel)   rdata_d = REG_W'(en_rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R8: every read strobe is answered on the next cycle
  a_r8_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
endmodule

// File: rtl/cycle_load_counters.sv
module cycle_load_counters
  import cyc_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT  = 8,
  parameter int unsigned NUM_BUSY = 8,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned THR_W    = 31,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IRQ_SRC  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BUSY-1:0] busy_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                reg_rvalid_o,
  output logic                irq_o
);
  logic [NUM_CNT-1:0]            wr_ctrl, wr_mask, wr_thr, wr_cnt, hit;
  logic [NUM_CNT-1:0][REG_W-1:0] ctrl_rd, mask_rd, thr_rd, cnt_rd;
  logic                          stat_clr, en_wr, stat, en;

  initial begin
    if (NUM_CNT > GRP_SLOTS || NUM_CNT == 0) $error("NUM_CNT out of range");
    if (CNT_W > REG_W || CNT_W < THR_W)      $error("CNT_W out of range");
    if (NUM_BUSY > REG_W || THR_W >= REG_W)  $error("field width out of range");
    if (IRQ_SRC >= NUM_CNT)                  $error("IRQ_SRC out of range");
    if (ADDR_W < 9)                          $error("ADDR_W too small");
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    cnt_mode_e           mode;
    logic [NUM_BUSY-1:0] mask;
    logic [THR_W-1:0]    thr;
    logic [CNT_W-1:0]    count;

    cyc_counter_unit #(
      .NUM_BUSY (NUM_BUSY),
      .CNT_W    (CNT_W),
      .THR_W    (THR_W)
    ) i_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_i    (busy_i),
      .wr_ctrl_i (wr_ctrl[i]),
      .wr_mask_i (wr_mask[i]),
      .wr_thr_i  (wr_thr[i]),
      .wr_cnt_i  (wr_cnt[i]),
      .wdata_i   (reg_wdata_i),
      .mode_o    (mode),
      .mask_o    (mask),
      .thr_o     (thr),
      .count_o   (count),
      .hit_o     (hit[i])
    );

    assign ctrl_rd[i] = REG_W'(mode);
    assign mask_rd[i] = REG_W'(mask);
    assign thr_rd[i]  = REG_W'(thr);
    assign cnt_rd[i]  = REG_W'(count);
  end

  cyc_reg_decode #(
    .NUM_CNT (NUM_CNT),
    .ADDR_W  (ADDR_W)
  ) i_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ctrl_rd_i  (ctrl_rd),
    .mask_rd_i  (mask_rd),
    .thr_rd_i   (thr_rd),
    .cnt_rd_i   (cnt_rd),
    .stat_rd_i  (stat),
    .en_rd_i    (en),
    .wr_ctrl_o  (wr_ctrl),
    .wr_mask_o  (wr_mask),
    .wr_thr_o   (wr_thr),
    .wr_cnt_o   (wr_cnt),
    .stat_clr_o (stat_clr),
    .en_wr_o    (en_wr),
    .rdata_o    (reg_rdata_o),
    .rvalid_o   (reg_rvalid_o)
  );

  cyc_irq_ctrl i_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit[IRQ_SRC]),
    .stat_clr_i (stat_clr),
    .en_wr_i    (en_wr),
    .en_wdata_i (reg_wdata_i[0]),
    .stat_o     (stat),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  // R7: the line never rises while the enable is off
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_o);
endmodule

// File: tb/test_cycle_load_counters.sv
`timescale 1ns/1ps
module test_cycle_load_counters;
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_MASK = 12'h040;
  localparam logic [11:0] A_THR  = 12'h080;
  localparam logic [11:0] A_CNT  = 12'h0C0;
  localparam logic [11:0] A_STAT = 12'h100;
  localparam logic [11:0] A_EN   = 12'h104;
  localparam logic [31:0] RST_CMD = 32'h8000_0000;

  logic        clk, rst_n;
  logic [7:0]  busy;
  logic        wr_s, rd_s;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        rvalid, irq;
  int          total, bad;
  bit          done;

  cycle_load_counters i_cycle_load_counters (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy),
    .reg_wr_i     (wr_s),
    .reg_rd_i     (rd_s),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .reg_rvalid_o (rvalid),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge and uses one rising edge
  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    wr_s = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_s = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    rd_s = 1'b1; addr = a;
    @(negedge clk);
    rd_s = 1'b0;
    d = rdata;
    chk("R8 rvalid", 32'(rvalid), 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_rd(A_CNT, v);          chk("R1 count0", v, 32'd0);
    reg_rd(A_STAT, v);         chk("R1 status", v, 32'd0);
    reg_rd(A_EN, v);           chk("R1 enable", v, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    reg_rd(A_THR, v);          chk("R1 threshold", v, 32'h7FFF_FFFF);
    reg_rd(A_CTRL, v);         chk("R1 mode", v, 32'd0);
    reg_rd(A_MASK + 12'd8, v); chk("R1 mask2", v, 32'd0);
    idle(1);
    chk("R8 rvalid idle", 32'(rvalid), 32'd0);
    idle(4);
    reg_rd(A_CNT + 12'd12, v); chk("R3 zero mask count3", v, 32'd0);
  endtask

  task automatic t_always;
    logic [31:0] v;
    reg_wr(A_CTRL, 32'd1);
    reg_wr(A_CNT, RST_CMD);        // edge e0, collides with a count event
    reg_rd(A_CNT, v);  chk("R4 reset beats count", v, 32'd0);
    idle(5);
    reg_rd(A_CNT, v);  chk("R2 every edge", v, 32'd6);
    reg_wr(A_CNT, 32'h0000_1234);  // no reset bit
    reg_rd(A_CNT, v);  chk("R4 write without reset bit", v, 32'd8);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    reg_wr(A_MASK + 12'd16, 32'h05);
    reg_wr(A_CNT + 12'd16, RST_CMD);
    busy = 8'h01; idle(3);
    busy = 8'h02; idle(4);
    busy = 8'h04; idle(3);
    busy = 8'h05; idle(2);
    busy = 8'h00;
    reg_rd(A_CNT + 12'd16, v); chk("R3 masked busy count4", v, 32'd8);
    reg_rd(A_CNT + 12'd20, v); chk("R3 zero mask count5", v, 32'd0);
  endtask

  task automatic t_threshold;
    logic [31:0] v;
    reg_wr(A_THR, 32'hFFFF_FFFF);
    reg_rd(A_THR, v);  chk("R5 threshold 31 bits", v, 32'h7FFF_FFFF);
    reg_wr(A_THR, 32'd10);
    reg_wr(A_CNT, RST_CMD);        // e0
    reg_wr(A_STAT, 32'd1);         // e0+1
    idle(7);                       // to e0+8
    reg_rd(A_STAT, v); chk("R5 before crossing", v, 32'd0);
    reg_rd(A_STAT, v); chk("R5 at crossing edge", v, 32'd0);
    reg_rd(A_STAT, v); chk("R5 after crossing", v, 32'd1);
    chk("R7 latched without irq", 32'(irq), 32'd0);
    reg_wr(A_EN, 32'd1);
    chk("R7 irq enabled", 32'(irq), 32'd1);
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    reg_wr(A_CNT, RST_CMD);
    reg_rd(A_STAT, v); chk("R6 survives counter reset", v, 32'd1);
    reg_wr(A_STAT, 32'd0);
    reg_rd(A_STAT, v); chk("R6 write 0 ignored", v, 32'd1);
    reg_wr(A_STAT, 32'd1);
    reg_rd(A_STAT, v); chk("R6 write 1 clears", v, 32'd0);
    chk("R7 irq low after clear", 32'(irq), 32'd0);
    reg_wr(A_THR, 32'h7FFF_FFFF);
  endtask

  task automatic t_other_src;
    logic [31:0] v;
    reg_wr(A_CTRL + 12'd4, 32'd1);
    reg_wr(A_THR + 12'd4, 32'd3);
    reg_wr(A_CNT + 12'd4, RST_CMD);
    idle(8);
    reg_rd(A_STAT, v); chk("R5 other counter ignored", v, 32'd0);
    chk("R7 irq stays low", 32'(irq), 32'd0);
  endtask

  task automatic t_coincide;
    logic [31:0] v;
    reg_wr(A_THR, 32'd5);
    reg_wr(A_CNT, RST_CMD);        // e0
    reg_wr(A_STAT, 32'd1);         // e0+1
    idle(3);                       // to e0+4
    reg_wr(A_STAT, 32'd1);         // e0+5, crossing edge
    reg_rd(A_STAT, v); chk("R9 set beats clear", v, 32'd1);
    chk("R7 irq on", 32'(irq), 32'd1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    reg_rd(12'h1FC, v);         chk("R8 unmapped page", v, 32'd0);
    reg_rd(12'h108, v);         chk("R8 unmapped word", v, 32'd0);
    reg_rd(A_CNT + 12'd36, v);  chk("R8 index beyond bank", v, 32'd0);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; busy = '0; wr_s = 1'b0; rd_s = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_always();
    t_masked();
    t_threshold();
    t_sticky();
    t_other_src();
    t_coincide();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule